// File: doc/BRIEF.md
# I/O Wait-State Handshake Bridge

This block lets an 8-bit host CPU talk to a slow I/O coprocessor through ordinary I/O instructions. When the host opens an I/O read or write, the bridge sets an internal hold flag. The flag pulls the host's active-low wait line and sends a one-cycle service pulse to the coprocessor. On a write, the port byte (the low address byte) and the data byte are held for the coprocessor to read. On a read, the port byte is held, and the coprocessor supplies a response byte.

The coprocessor ends the stall with a release pulse. On a read cycle, the release also captures the response byte. The bridge then enables its data-bus drivers only while the host still holds the I/O request and read strobes low. The drivers turn off as soon as either strobe rises, so the bus is never contended. All host control, address and data inputs pass through a two-stage synchronizer into the bridge's clock domain. A single long I/O cycle arms the flag only once. Interrupt-acknowledge cycles, in which the opcode-fetch strobe is low together with the I/O request, never set the flag.

Top module: `io_wait_bridge`

## Requirements
- R1: After reset, host_wait_n is 1, cop_irq is 0 and host_data_oe is 0.
- R2: If host_iorq_n is low together with host_rd_n or host_wr_n low, and host_m1_n is high, the hold flag sets on the third rising clock edge after the pins change. host_wait_n then goes to 0, and cop_irq is 1 for exactly that one cycle.
- R3: A write cycle (host_wr_n low) presents host_addr_lo on cop_port and host_data_in on cop_wdata, with cop_dir_wr = 1, from the cycle in which cop_irq is high.
- R4: A read cycle (host_rd_n low) presents host_addr_lo on cop_port with cop_dir_wr = 0.
- R5: host_wait_n stays 0 until cop_release is sampled high on a clock edge. It returns to 1 right after that edge.
- R6: On a read cycle, the release edge captures cop_rdata. host_data_out then shows the captured byte, and host_data_oe is 1 while host_iorq_n and host_rd_n are both low. Later changes of cop_rdata do not alter host_data_out.
- R7: host_data_oe drops to 0 without waiting for a clock edge when host_iorq_n or host_rd_n goes high.
- R8: With host_m1_n low, an I/O request never sets the flag: host_wait_n stays 1 and cop_irq stays 0.
- R9: After a release, the flag does not set again while host_iorq_n stays low. A new cycle is accepted once host_iorq_n has been seen high through the synchronizer.
- R10: A cop_release pulse while the flag is clear has no effect. host_data_oe is never 1 for a write cycle.
- R11: host_iorq_n low with both host_rd_n and host_wr_n high does not stall the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_iorq_n | input | 1 | Host I/O request, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_m1_n | input | 1 | Host opcode-fetch strobe, active low |
| host_addr_lo | input | 8 | Host low address byte (port number) |
| host_data_in | input | 8 | Host data bus as seen by the bridge |
| host_wait_n | output | 1 | Wait line to the host, active low |
| host_data_out | output | 8 | Response byte for the host data bus |
| host_data_oe | output | 1 | Drive enable for host_data_out |
| cop_irq | output | 1 | One-cycle service request to the coprocessor |
| cop_dir_wr | output | 1 | 1 when the held cycle is a write |
| cop_port | output | 8 | Captured port byte |
| cop_wdata | output | 8 | Captured write data |
| cop_rdata | input | 8 | Response byte from the coprocessor |
| cop_release | input | 1 | Release pulse ending the stall |

## Verification
The host pins are driven on falling clock edges. The hold flag, host_wait_n, cop_irq and the captured port and data bytes are due on the third rising edge after that. The bench checks host_wait_n still high just after the second edge and checks all of these just after the third. A release takes effect on the single edge where it is sampled, so host_wait_n, host_data_oe and host_data_out are checked just after that edge. The drop of host_data_oe is checked one time step after the strobe rises, with no clock edge between. Re-arming needs three edges after host_iorq_n rises, so every new cycle starts at least four edges later. Every port value is swept in both directions.

// File: rtl/iowh_pkg.sv
package iowh_pkg;

    typedef struct packed {
        logic flag;
        logic armed;
        logic irq;
        logic wr;
        logic resp_valid;
    } core_state_t;

    localparam int unsigned CTRL_BITS = 4;

endpackage

// File: rtl/iowh_sync.sv
module iowh_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = din;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/iowh_core.sv
module iowh_core
    import iowh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_iorq_n,
    input  logic s_rd_n,
    input  logic s_wr_n,
    input  logic s_m1_n,
    input  logic release_i,
    output logic set_o,
    output logic grab_o,
    output logic flag_o,
    output logic irq_o,
    output logic wr_o,
    output logic resp_valid_o
);

    core_state_t st_d, st_q;
    logic io_req;

    always_comb begin
        st_d   = st_q;
        io_req = !s_iorq_n && (!s_rd_n || !s_wr_n) && s_m1_n;
        set_o  = io_req && st_q.armed && !st_q.flag;
        grab_o = st_q.flag && release_i && !st_q.wr;
        st_d.irq = set_o;
        if (set_o) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
            st_d.wr    = !s_wr_n;
        end
        if (st_q.flag && release_i) begin
            st_d.flag = 1'b0;
            if (!st_q.wr) st_d.resp_valid = 1'b1;
        end
        if (s_iorq_n) begin
            st_d.armed      = 1'b1;
            st_d.resp_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0, armed: 1'b1, irq: 1'b0, wr: 1'b0, resp_valid: 1'b0};
        else        st_q <= st_d;
    end

    assign flag_o       = st_q.flag;
    assign irq_o        = st_q.irq;
    assign wr_o         = st_q.wr;
    assign resp_valid_o = st_q.resp_valid;

    a_r5_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !release_i) |=> st_q.flag);
    a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);
    a_r2_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.flag);
    a_r8_m1_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.flag && !s_m1_n) |=> !st_q.flag);
    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.flag && !st_q.armed) |=> !st_q.flag);
    a_r10_write_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && st_q.wr) |=> !st_q.resp_valid);

endmodule

// File: rtl/iowh_latch.sv
module iowh_latch #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              grab_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] port_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] port;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (set_i) begin
            h_d.port  = addr_i;
            h_d.wdata = wdata_i;
        end
        if (grab_i) h_d.rdata = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign port_o  = h_q.port;
    assign wdata_o = h_q.wdata;
    assign rdata_o = h_q.rdata;

    a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !grab_i |=> $stable(h_q.rdata));

endmodule

// File: rtl/io_wait_bridge.sv
module io_wait_bridge
    import iowh_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_iorq_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_m1_n,
    input  logic [ADDR_W-1:0] host_addr_lo,
    input  logic [DATA_W-1:0] host_data_in,
    output logic              host_wait_n,
    output logic [DATA_W-1:0] host_data_out,
    output logic              host_data_oe,
    output logic              cop_irq,
    output logic              cop_dir_wr,
    output logic [ADDR_W-1:0] cop_port,
    output logic [DATA_W-1:0] cop_wdata,
    input  logic [DATA_W-1:0] cop_rdata,
    input  logic              cop_release
);

    localparam int unsigned SYNC_W = CTRL_BITS + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CTRL_BITS{1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic s_iorq_n, s_rd_n, s_wr_n, s_m1_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic set_w, grab_w, flag_w, irq_w, wr_w, resp_valid_w;

    assign raw_bus = {host_m1_n, host_iorq_n, host_rd_n, host_wr_n, host_addr_lo, host_data_in};

    iowh_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_bus), .dout(sync_bus)
    );

    assign {s_m1_n, s_iorq_n, s_rd_n, s_wr_n, s_addr, s_data} = sync_bus;

    iowh_core u_core (
        .clk(clk), .rst_n(rst_n),
        .s_iorq_n(s_iorq_n), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_m1_n(s_m1_n),
        .release_i(cop_release),
        .set_o(set_w), .grab_o(grab_w), .flag_o(flag_w), .irq_o(irq_w),
        .wr_o(wr_w), .resp_valid_o(resp_valid_w)
    );

    iowh_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .set_i(set_w), .grab_i(grab_w),
        .addr_i(s_addr), .wdata_i(s_data), .rdata_i(cop_rdata),
        .port_o(cop_port), .wdata_o(cop_wdata), .rdata_o(host_data_out)
    );

    assign host_wait_n  = !flag_w;
    assign cop_irq      = irq_w;
    assign cop_dir_wr   = wr_w;
    assign host_data_oe = resp_valid_w && !host_iorq_n && !host_rd_n;

    a_r6_oe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_oe |-> host_wait_n);
    a_r10_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_oe |-> !cop_dir_wr);
    a_r2_wait_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_wait_n) |-> cop_irq);

endmodule

// File: tb/sim_io_wait_bridge.sv
module sim_io_wait_bridge;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic [7:0] addr = '0, din = '0, rdata = '0;
    logic rel = 1'b0;
    logic wait_n, oe, irq, dir_wr;
    logic [7:0] dout, port, wdata;

    int errors = 0;
    int checks = 0;
    int irq_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    io_wait_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .host_iorq_n(iorq_n), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_m1_n(m1_n),
        .host_addr_lo(addr), .host_data_in(din),
        .host_wait_n(wait_n), .host_data_out(dout), .host_data_oe(oe),
        .cop_irq(irq), .cop_dir_wr(dir_wr), .cop_port(port), .cop_wdata(wdata),
        .cop_rdata(rdata), .cop_release(rel)
    );

    always @(posedge clk) if (irq === 1'b1) irq_seen++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        addr = p; din = d; iorq_n = 0; wr_n = 0;
        edges(2);
        chk(wait_n == 1, "R2 wait early", wait_n, 1);
        edges(1);
        chk(wait_n == 0 && irq == 1, "R2 stall", {wait_n, irq}, 2'b01);
        chk(port == p && wdata == d, "R3 capture", {port, wdata}, {p, d});
        chk(dir_wr == 1, "R3 dir", dir_wr, 1);
        edges(1);
        chk(irq == 0, "R2 irq single", irq, 0);
        edges(3);
        chk(wait_n == 0, "R5 held", wait_n, 0);
        @(negedge clk); rel = 1;
        edges(1);
        chk(wait_n == 1 && oe == 0, "R5 R10 release write", {wait_n, oe}, 2'b10);
        @(negedge clk); rel = 0; iorq_n = 1; wr_n = 1;
        edges(4);
    endtask

    task automatic host_read(input logic [7:0] p, input logic [7:0] r, input bit iorq_first);
        @(negedge clk);
        addr = p; din = 8'hEE; iorq_n = 0; rd_n = 0;
        edges(2);
        chk(wait_n == 1, "R2 wait early", wait_n, 1);
        edges(1);
        chk(wait_n == 0 && irq == 1, "R2 stall", {wait_n, irq}, 2'b01);
        chk(port == p && dir_wr == 0, "R4 capture", {port, dir_wr}, {p, 1'b0});
        chk(oe == 0, "R6 no oe while held", oe, 0);
        @(negedge clk); rdata = r; rel = 1;
        edges(1);
        chk(wait_n == 1 && oe == 1 && dout == r, "R6 drive", {wait_n, oe, dout}, {2'b11, r});
        @(negedge clk); rel = 0; rdata = ~r;
        edges(1);
        chk(dout == r && oe == 1, "R6 latched", {oe, dout}, {1'b1, r});
        @(negedge clk);
        if (iorq_first) iorq_n = 1; else rd_n = 1;
        #1;
        chk(oe == 0, "R7 oe drop", oe, 0);
        @(negedge clk); iorq_n = 1; rd_n = 1;
        edges(4);
    endtask

    initial begin
        edges(3);
        chk(wait_n == 1 && irq == 0 && oe == 0, "R1 reset", {wait_n, irq, oe}, 3'b100);
        @(negedge clk); rst_n = 1;
        edges(2);

        for (int p = 0; p < 256; p++) host_write(8'(p), 8'(p * 7 + 3));
        for (int p = 0; p < 256; p++) host_read(8'(p), 8'(p) ^ 8'hA5, p[0]);

        // R8: interrupt acknowledge ignored
        irq_seen = 0;
        @(negedge clk); m1_n = 0; iorq_n = 0; rd_n = 0;
        edges(8);
        chk(wait_n == 1 && irq_seen == 0, "R8 m1 ignored", {wait_n, 8'(irq_seen)}, 9'h100);
        @(negedge clk); m1_n = 1; iorq_n = 1; rd_n = 1;
        edges(4);

        // R11: request without strobe
        @(negedge clk); iorq_n = 0;
        edges(8);
        chk(wait_n == 1 && irq_seen == 0, "R11 no strobe", {wait_n, 8'(irq_seen)}, 9'h100);
        @(negedge clk); iorq_n = 1;
        edges(4);

        // R10: release while idle
        @(negedge clk); rdata = 8'h3C; rel = 1;
        edges(1);
        @(negedge clk); rel = 0; iorq_n = 0; rd_n = 0;
        #1;
        chk(wait_n == 1 && oe == 0, "R10 idle release", {wait_n, oe}, 2'b10);
        edges(3);
        chk(wait_n == 0, "R10 then stall", wait_n, 0);

        // R9: long cycle after release does not re-trigger
        @(negedge clk); rdata = 8'h5E; rel = 1;
        edges(1);
        @(negedge clk); rel = 0;
        irq_seen = 0;
        edges(10);
        chk(wait_n == 1 && irq_seen == 0, "R9 no retrigger", {wait_n, 8'(irq_seen)}, 9'h100);
        chk(oe == 1 && dout == 8'h5E, "R9 R6 still driving", {oe, dout}, 9'h15E);
        @(negedge clk); iorq_n = 1; rd_n = 1;
        edges(4);
        host_write(8'h42, 8'h99);
        chk(irq_seen == 1, "R9 rearm", irq_seen, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule